// File: doc/BRIEF.md
# Multiplexed Bus DMA Cycle Sequencer

This block lets a peripheral become master of an asynchronous system bus whose address and data share the same lines. On a start pulse it captures a word address, a byte-select bit, two extended address bits, a cycle kind and write data. It then raises a DMA request and waits for the daisy-chained grant. Once it holds the bus, it runs one of four transfer kinds against memory with a four-phase handshake built from sync, data-in, data-out, write-byte and reply. When the transfer finishes it gives the bus back and pulses `done`.

If memory never answers a data strobe within a set number of clock cycles, the cycle is abandoned and a nonexistent-memory error is pulsed. The same error is pulsed when the write half of a read-modify-write is not launched in time after its read half. All bus signals are modelled as active-high, with a separate output enable for the shared lines. Register decode, word counting and interrupts are handled by neighbouring logic.

Top module: `mbDmaSequencer`

## Requirements
- R1: A `start` pulse while idle raises `dmaReq` in the next cycle. When `grantIn` is high while requesting, the following cycle has `masterAck` high and `dmaReq` low.
- R2: `grantOut` follows `grantIn` while the block is neither requesting nor master. It is held low while `dmaReq` or `masterAck` is high.
- R3: Address phase:
  - `busDataOut` carries `{wordAddr, byteSel}` and `extAddrOut` carries `extAddr`, with `busDataOe` high.
  - The address is driven for one cycle before `syncOut` rises and stays on the lines during the first sync cycle.
  - `busDataOe` is low during the data-in strobe.
- R4: `cycType` encodes the cycle kind: 00 read, 01 read-modify-write, 10 word write, 11 byte write. `wtbtOut` is high in the address phase only for 10 and 11. During the data-out strobe it is high only for 11.
- R5: Read:
  - `dinOut` rises after the address is removed.
  - On `reply` the value on `busDataIn` is stored into `rdData` and `dinOut` drops.
  - Once `reply` is low, `syncOut` and `masterAck` drop and `done` pulses for one cycle.
- R6: Word write: `busDataOut` drives `wrData` as captured at start, with `busDataOe` and `doutOut` high until `reply`. After `reply` goes low, sync and mastership end and `done` pulses.
- R7: A byte write drives the full data word with `wtbtOut` held through the data phase. Memory then updates only the lane chosen by address bit 0: lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R8: Read-modify-write:
  - The read half stores `rdData` and keeps `syncOut` high.
  - A `rmwWrite` pulse launches the write half to the same address, with no new address phase.
  - The write half uses `wrData` as sampled with that pulse.
- R9: If `reply` has not come after the data strobe has been high for REPLY_TMO cycles, the strobe, sync and `masterAck` all drop and `nxmErr` pulses for one cycle instead of `done`.
- R10: If `rmwWrite` has not been sampled within RMW_TMO cycles after the read half ends, the cycle aborts as in R9 and memory is left unchanged.
- R11: `start` is ignored while a cycle is in progress. The running cycle keeps its kind and only one sync assertion occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a cycle (sampled when idle) |
| cycType | input | 2 | Cycle kind, see R4 |
| wordAddr | input | DATA_W-1 | Word address (bus bits above bit 0) |
| byteSel | input | 1 | Bus address bit 0 |
| extAddr | input | EXT_W | Extended address bits |
| wrData | input | DATA_W | Write data |
| rmwWrite | input | 1 | Launch write half of a read-modify-write |
| rdData | output | DATA_W | Last data read |
| done | output | 1 | One-cycle pulse at normal completion |
| nxmErr | output | 1 | One-cycle nonexistent-memory pulse |
| dmaReq | output | 1 | Bus request |
| grantIn | input | 1 | Grant from upstream |
| grantOut | output | 1 | Grant to downstream |
| masterAck | output | 1 | Bus master acknowledge |
| syncOut | output | 1 | Sync strobe |
| dinOut | output | 1 | Data-in strobe |
| doutOut | output | 1 | Data-out strobe |
| wtbtOut | output | 1 | Write/byte control |
| reply | input | 1 | Slave reply |
| busDataIn | input | DATA_W | Shared lines as received |
| busDataOut | output | DATA_W | Shared lines as driven |
| busDataOe | output | 1 | Drive enable for shared lines |
| extAddrOut | output | EXT_W | Extended address lines |

## Verification
The bench builds the block with REPLY_TMO of 12 and RMW_TMO of 24 cycles instead of the microsecond-scale defaults. These small values let it measure the exact reply-abort instant and probe both sides of the read-modify-write gap limit. A gap of RMW_TMO-1 idle cycles must still complete, and a gap of RMW_TMO must abort. The bench pairs the block with a behavioural memory that has random reply delay and an arbiter that can be switched to manual control. This lets it exercise grant passing and grant blocking directly.

// File: rtl/mbDmaPkg.sv
package mbDmaPkg;

  typedef enum logic [1:0] {
    CYC_READ   = 2'b00,
    CYC_RMW    = 2'b01,
    CYC_WRITE  = 2'b10,
    CYC_WRBYTE = 2'b11
  } cycKindT;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_ADDR, S_SYNC, S_RDWAIT, S_RDEND, S_HOLD, S_WRWAIT, S_WREND
  } seqStateT;

  typedef struct packed {
    logic capture;
    logic loadWrite;
    logic latchRead;
    logic driveAddr;
    logic driveData;
  } dpCtlT;

endpackage

// File: rtl/mbDmaCtl.sv
module mbDmaCtl
  import mbDmaPkg::*;
#(
  parameter int REPLY_TMO = 750,
  parameter int RMW_TMO   = 1500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] cycType,
  input  logic       rmwWrite,
  input  logic       grantIn,
  input  logic       reply,
  output dpCtlT      dpCtl,
  output logic       dmaReq,
  output logic       masterAck,
  output logic       syncOut,
  output logic       dinOut,
  output logic       doutOut,
  output logic       wtbtOut,
  output logic       done,
  output logic       nxmErr
);

  localparam int TMO_MAX = (REPLY_TMO > RMW_TMO) ? REPLY_TMO : RMW_TMO;
  localparam int TW      = $clog2(TMO_MAX + 1);

  seqStateT  state, nxt;
  cycKindT   kind;
  logic [TW-1:0] timer;
  logic finish, abort, waiting, isWrite;

  assign isWrite = kind[1];
  assign waiting = (state == S_RDWAIT) || (state == S_WRWAIT) || (state == S_HOLD);

  always_comb begin
    nxt    = state;
    finish = 1'b0;
    abort  = 1'b0;
    dpCtl  = '0;
    case (state)
      S_IDLE:   if (start) begin dpCtl.capture = 1'b1; nxt = S_REQ; end
      S_REQ:    if (grantIn) nxt = S_ADDR;
      S_ADDR:   begin dpCtl.driveAddr = 1'b1; nxt = S_SYNC; end
      S_SYNC:   begin dpCtl.driveAddr = 1'b1; nxt = isWrite ? S_WRWAIT : S_RDWAIT; end
      S_RDWAIT: begin
        if (reply) begin dpCtl.latchRead = 1'b1; nxt = S_RDEND; end
        else if (timer == TW'(REPLY_TMO - 1)) abort = 1'b1;
      end
      S_RDEND:  if (!reply) begin
        if (kind == CYC_RMW) nxt = S_HOLD;
        else finish = 1'b1;
      end
      S_HOLD: begin
        if (rmwWrite) begin dpCtl.loadWrite = 1'b1; nxt = S_WRWAIT; end
        else if (timer == TW'(RMW_TMO - 1)) abort = 1'b1;
      end
      S_WRWAIT: begin
        dpCtl.driveData = 1'b1;
        if (reply) nxt = S_WREND;
        else if (timer == TW'(REPLY_TMO - 1)) abort = 1'b1;
      end
      S_WREND:  if (!reply) finish = 1'b1;
      default:  nxt = S_IDLE;
    endcase
    if (finish || abort) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      kind   <= CYC_READ;
      timer  <= '0;
      done   <= 1'b0;
      nxmErr <= 1'b0;
    end else begin
      state  <= nxt;
      done   <= finish;
      nxmErr <= abort;
      if (dpCtl.capture) kind <= cycKindT'(cycType);
      if (nxt != state) timer <= '0;
      else if (waiting) timer <= timer + 1'b1;
    end
  end

  assign dmaReq    = (state == S_REQ);
  assign masterAck = (state != S_IDLE) && (state != S_REQ);
  assign syncOut   = masterAck && (state != S_ADDR);
  assign dinOut    = (state == S_RDWAIT);
  assign doutOut   = (state == S_WRWAIT);
  assign wtbtOut   = (((state == S_ADDR) || (state == S_SYNC)) && isWrite) ||
                     ((state == S_WRWAIT) && (kind == CYC_WRBYTE));

  // R1: mastership only taken from a pending request that saw the grant
  a_r1_ack_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterAck) |-> ($past(dmaReq) && $past(grantIn)));
  // R3: data strobes only inside sync, never both at once
  a_r3_strobe_in_sync: assert property (@(posedge clk) disable iff (!rstN)
    (dinOut || doutOut) |-> (syncOut && !(dinOut && doutOut)));
  // R5: normal sync release only after reply was seen low
  a_r5_sync_release: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(syncOut) && !nxmErr) |-> !$past(reply));
  // R9: abort leaves the bus quiet and error is a single pulse
  a_r9_abort_clean: assert property (@(posedge clk) disable iff (!rstN)
    nxmErr |-> (!syncOut && !dinOut && !doutOut && !masterAck && !done));
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    nxmErr |=> !nxmErr);
  // R4: byte-write control only during a data-out strobe in the data phase
  a_r4_wtbt_data: assert property (@(posedge clk) disable iff (!rstN)
    (wtbtOut && syncOut && !dpCtl.driveAddr) |-> doutOut);

endmodule

// File: rtl/mbDmaDp.sv
module mbDmaDp
  import mbDmaPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             dpCtl,
  input  logic [DATA_W-2:0] wordAddr,
  input  logic              byteSel,
  input  logic [EXT_W-1:0]  extAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [EXT_W-1:0]  extAddrOut,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] addrReg, wrReg, rdReg;
  logic [EXT_W-1:0]  extReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      rdReg   <= '0;
      extReg  <= '0;
    end else begin
      if (dpCtl.capture) begin
        addrReg <= {wordAddr, byteSel};
        extReg  <= extAddr;
        wrReg   <= wrData;
      end
      if (dpCtl.loadWrite) wrReg <= wrData;
      if (dpCtl.latchRead) rdReg <= busDataIn;
    end
  end

  always_comb begin
    busDataOut = '0;
    if (dpCtl.driveAddr)      busDataOut = addrReg;
    else if (dpCtl.driveData) busDataOut = wrReg;
  end

  assign busDataOe  = dpCtl.driveAddr | dpCtl.driveData;
  assign extAddrOut = dpCtl.driveAddr ? extReg : '0;
  assign rdData     = rdReg;

  // R3: address and data never share a drive cycle
  a_r3_no_drive_clash: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtl.driveAddr && dpCtl.driveData));
  // R5: read latch never coincides with driving the lines
  a_r5_latch_undriven: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.latchRead |-> !busDataOe);

endmodule

// File: rtl/mbDmaSequencer.sv
module mbDmaSequencer
  import mbDmaPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int EXT_W     = 2,
  parameter int REPLY_TMO = 750,
  parameter int RMW_TMO   = 1500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cycType,
  input  logic [DATA_W-2:0] wordAddr,
  input  logic              byteSel,
  input  logic [EXT_W-1:0]  extAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rmwWrite,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              nxmErr,
  output logic              dmaReq,
  input  logic              grantIn,
  output logic              grantOut,
  output logic              masterAck,
  output logic              syncOut,
  output logic              dinOut,
  output logic              doutOut,
  output logic              wtbtOut,
  input  logic              reply,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [EXT_W-1:0]  extAddrOut
);

  dpCtlT dpCtl;

  mbDmaCtl #(.REPLY_TMO(REPLY_TMO), .RMW_TMO(RMW_TMO)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .cycType(cycType),
    .rmwWrite(rmwWrite), .grantIn(grantIn), .reply(reply), .dpCtl(dpCtl),
    .dmaReq(dmaReq), .masterAck(masterAck), .syncOut(syncOut),
    .dinOut(dinOut), .doutOut(doutOut), .wtbtOut(wtbtOut),
    .done(done), .nxmErr(nxmErr)
  );

  mbDmaDp #(.DATA_W(DATA_W), .EXT_W(EXT_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .wordAddr(wordAddr),
    .byteSel(byteSel), .extAddr(extAddr), .wrData(wrData),
    .busDataIn(busDataIn), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .extAddrOut(extAddrOut), .rdData(rdData)
  );

  assign grantOut = grantIn & ~dmaReq & ~masterAck;

  // R2: a grant that passes downstream was not needed here
  a_r2_grant_pass: assert property (@(posedge clk) disable iff (!rstN)
    grantOut |=> !masterAck);

endmodule

// File: tb/tb_mbDmaSequencer.sv
module tb_mbDmaSequencer;
  localparam int DW = 16;
  localparam int EW = 2;
  localparam int RT = 12;
  localparam int MT = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, start, byteSel, rmwWrite, grantIn, reply;
  logic [1:0] cycType;
  logic [DW-2:0] wordAddr;
  logic [EW-1:0] extAddr;
  logic [DW-1:0] wrData, rdData, busDataIn, busDataOut;
  logic done, nxmErr, dmaReq, grantOut, masterAck, syncOut, dinOut, doutOut, wtbtOut, busDataOe;
  logic [EW-1:0] extAddrOut;

  mbDmaSequencer #(.DATA_W(DW), .EXT_W(EW), .REPLY_TMO(RT), .RMW_TMO(MT)) dut (
    .clk(clk), .rstN(rstN), .start(start), .cycType(cycType), .wordAddr(wordAddr),
    .byteSel(byteSel), .extAddr(extAddr), .wrData(wrData), .rmwWrite(rmwWrite),
    .rdData(rdData), .done(done), .nxmErr(nxmErr), .dmaReq(dmaReq), .grantIn(grantIn),
    .grantOut(grantOut), .masterAck(masterAck), .syncOut(syncOut), .dinOut(dinOut),
    .doutOut(doutOut), .wtbtOut(wtbtOut), .reply(reply), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .extAddrOut(extAddrOut)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] initPat(input int i);
    logic [3:0] n = i[3:0];
    return {n, ~n, n ^ 4'h5, 4'hA};
  endfunction

  function automatic logic [15:0] applyWrite(input logic [1:0] t, input logic [15:0] old,
                                             input logic [15:0] wd, input logic a0);
    if (t == 2'b11) return a0 ? {wd[15:8], old[7:0]} : {old[15:8], wd[7:0]};
    return wd;
  endfunction

  // behavioural memory slave and arbiter
  logic [15:0] mem [16];
  logic [15:0] expMem [16];
  logic slaveMute = 1'b0, arbAuto = 1'b1, manualGrant = 1'b0, arbGrant, syncPrev;
  int replyDelay = 0, dlyCnt, syncRises, doneCnt, errCnt;
  logic [15:0] capAddr;
  logic [1:0] capExt;
  logic capWtbt, capOe, capDataWtbt;

  assign grantIn = arbAuto ? arbGrant : manualGrant;

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= initPat(i);
      reply <= 1'b0; busDataIn <= '0; arbGrant <= 1'b0; syncPrev <= 1'b0;
      dlyCnt <= 0; syncRises <= 0; doneCnt <= 0; errCnt <= 0;
      capAddr <= '0; capExt <= '0; capWtbt <= 1'b0; capOe <= 1'b0; capDataWtbt <= 1'b0;
    end else begin
      syncPrev <= syncOut;
      if (done)   doneCnt <= doneCnt + 1;
      if (nxmErr) errCnt  <= errCnt + 1;
      if (syncOut && !syncPrev) begin
        capAddr <= busDataOut; capExt <= extAddrOut; capWtbt <= wtbtOut;
        capOe <= busDataOe; syncRises <= syncRises + 1;
      end
      if (masterAck) arbGrant <= 1'b0; else if (dmaReq) arbGrant <= 1'b1;
      if ((dinOut || doutOut) && !slaveMute) begin
        if (!reply) begin
          if (dlyCnt >= replyDelay) begin
            reply <= 1'b1; dlyCnt <= 0;
            if (dinOut) busDataIn <= mem[capAddr[4:1]];
            else begin
              capDataWtbt <= wtbtOut;
              if (wtbtOut && capAddr[0])  mem[capAddr[4:1]][15:8] <= busDataOut[15:8];
              else if (wtbtOut)           mem[capAddr[4:1]][7:0]  <= busDataOut[7:0];
              else                        mem[capAddr[4:1]]       <= busDataOut;
            end
          end else dlyCnt <= dlyCnt + 1;
        end
      end else begin
        dlyCnt <= 0;
        if (reply) reply <= 1'b0;
      end
    end
  end

  task automatic waitEnd(input int d0, input int e0);
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (doneCnt != d0 || errCnt != e0) break;
    end
    @(negedge clk);
  endtask

  // gap < 0 : no rmwWrite pulse; poke: hold start for a second cycle with another kind
  task automatic doCycle(input logic [1:0] t, input logic [14:0] wa, input logic [1:0] ex,
                         input logic bs, input logic [15:0] wd, input logic [15:0] wd2,
                         input int gap, input bit expErr, input bit poke);
    int d0 = doneCnt, e0 = errCnt, s0 = syncRises;
    int idx = int'(wa[3:0]);
    logic [15:0] old = expMem[idx];
    @(negedge clk);
    cycType = t; wordAddr = wa; extAddr = ex; byteSel = bs; wrData = wd;
    replyDelay = int'($urandom % 4);
    start = 1'b1;
    @(negedge clk);
    check("R1 request after start", {31'd0, dmaReq}, 32'd1);
    if (poke) begin cycType = ~t; wrData = ~wd; end
    else start = 1'b0;
    @(negedge clk);
    start = 1'b0; wrData = wd;
    if (t == 2'b01) begin
      while (!dinOut) @(negedge clk);
      while (dinOut) @(negedge clk);
      @(negedge clk);
      if (gap >= 0) begin
        repeat (gap) @(negedge clk);
        wrData = wd2; rmwWrite = 1'b1;
        @(negedge clk);
        rmwWrite = 1'b0;
      end
    end
    waitEnd(d0, e0);
    check("R3 address on lines", {16'd0, capAddr}, {16'd0, wa, bs});
    check("R3 extended address", {30'd0, capExt}, {30'd0, ex});
    check("R3 drive enable in address phase", {31'd0, capOe}, 32'd1);
    check("R4 write flag in address phase", {31'd0, capWtbt}, {31'd0, t[1]});
    if (poke || t == 2'b01) check("R11 R8 single sync per cycle", syncRises - s0, 1);
    if (expErr) begin
      check("R10 error pulse", errCnt - e0, 1);
      check("R10 no done", doneCnt - d0, 0);
      check("R10 memory unchanged", {16'd0, mem[idx]}, {16'd0, old});
      check("R10 read half kept", {16'd0, rdData}, {16'd0, old});
    end else begin
      check("R5 R6 done pulse", doneCnt - d0, 1);
      if (t == 2'b00) check("R5 read data", {16'd0, rdData}, {16'd0, old});
      if (t == 2'b01) begin
        check("R8 rmw read data", {16'd0, rdData}, {16'd0, old});
        expMem[idx] = wd2;
      end
      if (t[1]) begin
        expMem[idx] = applyWrite(t, old, wd, bs);
        check("R4 R7 byte flag in data phase", {31'd0, capDataWtbt}, {31'd0, t[0]});
      end
      check("R6 R7 R8 memory contents", {16'd0, mem[idx]}, {16'd0, expMem[idx]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rstN = 1'b0; start = 1'b0; cycType = '0; wordAddr = '0; byteSel = 1'b0;
    extAddr = '0; wrData = '0; rmwWrite = 1'b0;
    for (int i = 0; i < 16; i++) expMem[i] = initPat(i);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset state",
          {24'd0, dmaReq, masterAck, syncOut, dinOut, doutOut, busDataOe, done, nxmErr}, 32'd0);

    // R2 grant pass-through and blocking, R1 handover
    arbAuto = 1'b0; manualGrant = 1'b1;
    #1 check("R2 grant passes when idle", {31'd0, grantOut}, 32'd1);
    @(negedge clk); manualGrant = 1'b0;
    begin
      int d0 = doneCnt;
      cycType = 2'b00; wordAddr = 15'h0003; byteSel = 1'b0; extAddr = 2'b01; start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R1 request raised", {31'd0, dmaReq}, 32'd1);
      manualGrant = 1'b1;
      #1 check("R2 grant blocked while requesting", {31'd0, grantOut}, 32'd0);
      @(negedge clk);
      check("R1 ack taken, request dropped", {30'd0, masterAck, dmaReq}, 32'd2);
      check("R2 grant blocked while master", {31'd0, grantOut}, 32'd0);
      manualGrant = 1'b0;
      waitEnd(d0, errCnt);
      check("R5 read via manual grant", {16'd0, rdData}, {16'd0, expMem[3]});
    end
    arbAuto = 1'b1;

    // directed kinds
    doCycle(2'b10, 15'h0015, 2'b10, 1'b0, 16'hBEEF, 16'h0, -1, 0, 0);
    doCycle(2'b11, 15'h0016, 2'b11, 1'b1, 16'hA5C3, 16'h0, -1, 0, 0);
    doCycle(2'b11, 15'h0017, 2'b00, 1'b0, 16'h5A3C, 16'h0, -1, 0, 0);
    doCycle(2'b00, 15'h0016, 2'b00, 1'b0, 16'h0, 16'h0, -1, 0, 0);
    doCycle(2'b01, 15'h0009, 2'b01, 1'b0, 16'h0, 16'h1234, MT - 1, 0, 0);
    doCycle(2'b01, 15'h000A, 2'b01, 1'b0, 16'h0, 16'h4321, MT, 1, 0);
    doCycle(2'b01, 15'h000B, 2'b00, 1'b0, 16'h0, 16'h7777, -1, 1, 0);
    doCycle(2'b10, 15'h000C, 2'b00, 1'b0, 16'hC0DE, 16'h0, -1, 0, 1);

    // R9 reply timeout
    begin
      int cnt = 1;
      slaveMute = 1'b1;
      @(negedge clk);
      cycType = 2'b00; wordAddr = 15'h0002; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!dinOut) @(negedge clk);
      forever begin
        @(negedge clk);
        if (dinOut) cnt++; else break;
      end
      check("R9 strobe cycles before abort", cnt, RT);
      check("R9 error pulse", {31'd0, nxmErr}, 32'd1);
      check("R9 bus released", {28'd0, syncOut, masterAck, done, doutOut}, 32'd0);
      slaveMute = 1'b0;
      repeat (2) @(negedge clk);
    end

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] t = 2'($urandom % 4);
      doCycle(t, 15'($urandom), 2'($urandom), 1'($urandom), 16'($urandom),
              16'($urandom), int'($urandom % MT), 0, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule